// File: doc/BRIEF.md
# Alternating-Width Carrier Reload Sequencer

This block provides the timing base for a three-phase inverter PWM that uses triangular carrier modulation. A down-counting carrier counter runs from a period register. Each time the counter reaches zero, the block loads a pulse-width one-shot counter and starts it. The width comes from one of two width registers. When alternation is enabled, the two registers are used in turn, so the rising and falling halves of the triangle can carry different widths. A reload-phase flag shows which width register was used last.

The block also raises a one-cycle carrier interrupt. In the plain mode it fires on every carrier zero. In the decimated mode it fires once per N qualifying zeros, and only zeros whose reload phase matches a programmed polarity count as qualifying. Software writes the registers at any time, but the block acts on them only at carrier zeros, so a running period or a running pulse is never changed part-way through.

Top module: `carrier_reload_seq`

## Requirements
- R1: While `en` is high, the carrier counter counts down by one per clock. On the clock where it reads zero, it reloads the period value P, so carrier zeros occur every P+1 enabled clocks. While `en` is low, no counter in the block advances and no zero occurs. After reset the counter holds 0, so the first enabled clock is a zero.
- R2: Each carrier zero produces a single-cycle `os_start` pulse in the cycle after the zero clock. In that same cycle, `reload_phase` shows the width register that was just loaded.
- R3: With alternation on (control bit 0 = 1), successive zeros load width register A and width register B in turn. `reload_phase` is 0 after a load from A and 1 after a load from B. The phase flag resets to 1, so the first alternating zero uses A.
- R4: With alternation off, every zero loads width register A and `reload_phase` is 0.
- R5: After a start with width W, `os_done` pulses for one cycle once W enabled clocks have passed, counting from the start clock. A width of 0 behaves as 1. If a new zero arrives while the one-shot is still running, including on the clock where it would expire, the counter restarts and no done pulse is issued for the abandoned run.
- R6: With the interrupt mode off (control bit 1 = 0), `carrier_irq` pulses in the cycle after every zero.
- R7: With the interrupt mode on (control bit 1 = 1), only zeros whose new reload phase equals the polarity bit (control bit 2) count. A remaining-count register starts at 0. On a counted zero, if the remaining count is 0 or 1, `carrier_irq` pulses and the remaining count reloads from the occurrence setting; otherwise the remaining count decrements. An occurrence setting of 0 acts as 1. While the mode is off, the remaining count is held at 0.
- R8: The register map is: address 0 = period, 1 = width A, 2 = width B, 3 = occurrence setting, 4 = control. Writes to addresses 5 to 7 are ignored. A write changes nothing until the next carrier zero. A zero that coincides with a write uses the old value.
- R9: While reset is asserted, `os_start`, `os_done` and `carrier_irq` are 0 and `reload_phase` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable for carrier and one-shot |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Register write data |
| os_start | output | 1 | One-shot start strobe |
| os_done | output | 1 | One-shot expiry strobe |
| reload_phase | output | 1 | Width register used at the last zero (0 = A, 1 = B) |
| carrier_irq | output | 1 | Carrier interrupt pulse |

## Verification
The bench targets five corner cases:

- Periods of zero length. A design that reloads one cycle late would show gaps between starts.
- Widths longer than the period. A design that lets the old run finish would emit a stray done pulse.
- A width setting of 0. A design that treats it literally would hang or underflow the one-shot.
- Decimated interrupts with each polarity and with an occurrence setting of 0. A design that counts zeros in the wrong phase, or that treats 0 as 256, would shift or lose interrupt pulses.
- Register writes made mid-period, and writes to unused addresses. A design that applies writes at once would cut a period short, and one that decodes the spare addresses would disturb the waveform.

// File: rtl/crs_pkg.sv
package crs_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERIOD  = 3'd0,
    REG_WIDTH_A = 3'd1,
    REG_WIDTH_B = 3'd2,
    REG_OCCUR   = 3'd3,
    REG_CTRL    = 3'd4
  } reg_addr_e;

  // packed: irq_pol is bit 2, irq_decim bit 1, alt_en bit 0
  typedef struct packed {
    logic irq_pol;
    logic irq_decim;
    logic alt_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/crs_regs.sv
module crs_regs
  import crs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OCC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] width_a,
  output logic [DATA_W-1:0] width_b,
  output logic [OCC_W-1:0]  occ_set,
  output ctrl_t             ctrl
);

  localparam int NUM_WIDTH = 2;

  logic [DATA_W-1:0] period_q, period_nxt;
  logic [OCC_W-1:0]  occ_q, occ_nxt;
  ctrl_t             ctrl_q, ctrl_nxt;
  logic [DATA_W-1:0] width_q [NUM_WIDTH];

  always_comb begin
    period_nxt = period_q;
    occ_nxt    = occ_q;
    ctrl_nxt   = ctrl_q;
    if (wr_en) begin
      unique case (wr_addr)
        REG_PERIOD: period_nxt = wr_data;
        REG_OCCUR:  occ_nxt    = wr_data[OCC_W-1:0];
        REG_CTRL:   ctrl_nxt   = ctrl_t'(wr_data[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      occ_q    <= '0;
      ctrl_q   <= '0;
    end else begin
      period_q <= period_nxt;
      occ_q    <= occ_nxt;
      ctrl_q   <= ctrl_nxt;
    end
  end

  for (genvar g = 0; g < NUM_WIDTH; g++) begin : g_width
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_WIDTH_A) + ADDR_W'(g);
    logic [DATA_W-1:0] w_nxt;
    always_comb begin
      w_nxt = width_q[g];
      if (wr_en && (wr_addr == MY_ADDR)) w_nxt = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) width_q[g] <= '0;
      else        width_q[g] <= w_nxt;
    end
  end

  assign period  = period_q;
  assign width_a = width_q[0];
  assign width_b = width_q[1];
  assign occ_set = occ_q;
  assign ctrl    = ctrl_q;

  // R8: a write to a spare address leaves the stored registers untouched
  assert_spare_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > ADDR_W'(REG_CTRL)) |=>
      ($stable(period_q) && $stable(occ_q) && $stable(ctrl_q)));

endmodule

// File: rtl/crs_carrier.sv
module crs_carrier #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] period,
  output logic              zero_evt
);

  logic [DATA_W-1:0] cnt_q, cnt_nxt;
  logic              at_zero;

  assign at_zero  = (cnt_q == '0);
  assign zero_evt = en && at_zero;

  always_comb begin
    cnt_nxt = cnt_q;
    if (en) begin
      if (at_zero) cnt_nxt = period;
      else         cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R1: zero reloads the period value
  assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (cnt_q == $past(period)));

  // R1: nothing moves while enable is low
  assert_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));

endmodule

// File: rtl/crs_oneshot.sv
module crs_oneshot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              zero_evt,
  input  logic              alt_en,
  input  logic [DATA_W-1:0] width_a,
  input  logic [DATA_W-1:0] width_b,
  output logic              sel,
  output logic              phase,
  output logic              os_start,
  output logic              os_done
);

  logic [DATA_W-1:0] wcnt_q, wcnt_nxt;
  logic              busy_q, busy_nxt;
  logic              phase_q, phase_nxt;
  logic              start_q, start_nxt;
  logic              done_q, done_nxt;
  logic [DATA_W-1:0] width_ld;

  assign sel      = alt_en ? ~phase_q : 1'b0;
  assign width_ld = sel ? width_b : width_a;

  always_comb begin
    wcnt_nxt  = wcnt_q;
    busy_nxt  = busy_q;
    phase_nxt = phase_q;
    start_nxt = 1'b0;
    done_nxt  = 1'b0;
    if (zero_evt) begin
      wcnt_nxt  = width_ld;
      busy_nxt  = 1'b1;
      phase_nxt = sel;
      start_nxt = 1'b1;
    end else if (en && busy_q) begin
      if (wcnt_q <= DATA_W'(1)) begin
        wcnt_nxt = '0;
        busy_nxt = 1'b0;
        done_nxt = 1'b1;
      end else begin
        wcnt_nxt = wcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      busy_q  <= 1'b0;
      phase_q <= 1'b1;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      wcnt_q  <= wcnt_nxt;
      busy_q  <= busy_nxt;
      phase_q <= phase_nxt;
      start_q <= start_nxt;
      done_q  <= done_nxt;
    end
  end

  assign phase    = phase_q;
  assign os_start = start_q;
  assign os_done  = done_q;

  // R5: done is a single-cycle strobe
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: a restart never reports done for the abandoned run
  assert_done_vs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !start_q);

  // R3: with alternation on, each start flips the phase
  assert_phase_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && $past(alt_en && rst_n)) |-> (phase_q != $past(phase_q)));

  // R4: without alternation, loads always come from width A
  assert_phase_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && $past(!alt_en && rst_n)) |-> !phase_q);

endmodule

// File: rtl/crs_irq.sv
module crs_irq #(
  parameter int OCC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_evt,
  input  logic             sel,
  input  logic             decim,
  input  logic             pol,
  input  logic [OCC_W-1:0] occ_set,
  output logic             irq
);

  logic [OCC_W-1:0] occ_q, occ_nxt;
  logic             irq_q, irq_nxt;

  always_comb begin
    occ_nxt = occ_q;
    irq_nxt = 1'b0;
    if (zero_evt) begin
      if (!decim) begin
        irq_nxt = 1'b1;
        occ_nxt = '0;
      end else if (sel == pol) begin
        if (occ_q <= OCC_W'(1)) begin
          irq_nxt = 1'b1;
          occ_nxt = occ_set;
        end else begin
          occ_nxt = occ_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      irq_q <= 1'b0;
    end else begin
      occ_q <= occ_nxt;
      irq_q <= irq_nxt;
    end
  end

  assign irq = irq_q;

  // R6: plain mode interrupts on every zero
  assert_irq_every_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(zero_evt && !decim && rst_n) |-> irq_q);

  // R7: interrupts only follow a carrier zero
  assert_irq_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(zero_evt && rst_n));

  // R7: in decimated mode, zeros of the wrong phase never interrupt
  assert_irq_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(zero_evt && decim && (sel != pol) && rst_n) |-> !irq_q);

endmodule

// File: rtl/carrier_reload_seq.sv
module carrier_reload_seq
  import crs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OCC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              os_start,
  output logic              os_done,
  output logic              reload_phase,
  output logic              carrier_irq
);

  logic [DATA_W-1:0] period, width_a, width_b;
  logic [OCC_W-1:0]  occ_set;
  ctrl_t             ctrl;
  logic              zero_evt;
  logic              sel;

  crs_regs #(.DATA_W(DATA_W), .OCC_W(OCC_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .period  (period),
    .width_a (width_a),
    .width_b (width_b),
    .occ_set (occ_set),
    .ctrl    (ctrl)
  );

  crs_carrier #(.DATA_W(DATA_W)) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .period   (period),
    .zero_evt (zero_evt)
  );

  crs_oneshot #(.DATA_W(DATA_W)) u_oneshot (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .zero_evt (zero_evt),
    .alt_en   (ctrl.alt_en),
    .width_a  (width_a),
    .width_b  (width_b),
    .sel      (sel),
    .phase    (reload_phase),
    .os_start (os_start),
    .os_done  (os_done)
  );

  crs_irq #(.OCC_W(OCC_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .zero_evt (zero_evt),
    .sel      (sel),
    .decim    (ctrl.irq_decim),
    .pol      (ctrl.irq_pol),
    .occ_set  (occ_set),
    .irq      (carrier_irq)
  );

  // R2: start and interrupt only appear together with a fresh phase
  assert_irq_with_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_irq |-> os_start);

endmodule

// File: tb/carrier_reload_seq_tb_top.sv
module carrier_reload_seq_tb_top;

  localparam int DATA_W = 16;
  localparam int OCC_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              en;
  logic              wr_en;
  logic [2:0]        wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              os_start, os_done, reload_phase, carrier_irq;

  always #2.5 clk = ~clk;

  carrier_reload_seq #(.DATA_W(DATA_W), .OCC_W(OCC_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .os_start     (os_start),
    .os_done      (os_done),
    .reload_phase (reload_phase),
    .carrier_irq  (carrier_irq)
  );

  typedef struct packed {
    logic start;
    logic done;
    logic phase;
    logic irq;
  } exp_t;

  exp_t  exp_q[$];
  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R9";
  bit    finished = 0;

  // ---------------- reference model (requirement-level) ----------------
  int unsigned m_cnt, m_period, m_wa, m_wb, m_wcnt, m_occ, m_occset;
  bit m_busy, m_phase, m_alt, m_decim, m_pol;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_period = 0; m_wa = 0; m_wb = 0; m_wcnt = 0;
      m_occ = 0; m_occset = 0; m_busy = 0; m_phase = 1;
      m_alt = 0; m_decim = 0; m_pol = 0;
    end else begin
      exp_t e;
      bit   z, s;
      e = '0;
      z = en && (m_cnt == 0);
      if (z) begin
        s = m_alt ? !m_phase : 1'b0;          // R3 / R4
        m_wcnt  = s ? m_wb : m_wa;
        m_busy  = 1;
        m_phase = s;
        m_cnt   = m_period;                   // R1
        e.start = 1;                          // R2
        if (!m_decim) begin                   // R6
          e.irq = 1; m_occ = 0;
        end else if (s == m_pol) begin        // R7
          if (m_occ <= 1) begin e.irq = 1; m_occ = m_occset; end
          else m_occ = m_occ - 1;
        end
      end else if (en) begin
        m_cnt = m_cnt - 1;
        if (m_busy) begin                     // R5
          if (m_wcnt <= 1) begin m_busy = 0; m_wcnt = 0; e.done = 1; end
          else m_wcnt = m_wcnt - 1;
        end
      end
      e.phase = m_phase;
      if (wr_en) begin                        // R8 map
        case (wr_addr)
          3'd0: m_period = wr_data;
          3'd1: m_wa     = wr_data;
          3'd2: m_wb     = wr_data;
          3'd3: m_occset = wr_data[OCC_W-1:0];
          3'd4: begin m_alt = wr_data[0]; m_decim = wr_data[1]; m_pol = wr_data[2]; end
          default: ;
        endcase
      end
      exp_q.push_back(e);
    end
  end

  // ---------------- monitor / scoreboard ----------------
  task automatic cmp(input string req, input string fld, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (%s) %s actual=%b expected=%b at %0t", req, cur_req, fld, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      cmp("R2", "os_start",     os_start,     e.start);
      cmp("R5", "os_done",      os_done,      e.done);
      cmp("R3", "reload_phase", reload_phase, e.phase);
      cmp("R7", "carrier_irq",  carrier_irq,  e.irq);
    end
  end

  // ---------------- driver ----------------
  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    run(3);
    // R9: reset state
    cur_req = "R9 reset";
    cmp("R9", "os_start",     os_start,     1'b0);
    cmp("R9", "os_done",      os_done,      1'b0);
    cmp("R9", "reload_phase", reload_phase, 1'b1);
    cmp("R9", "carrier_irq",  carrier_irq,  1'b0);
    rst_n = 1'b1;

    // R1 R2 R3 R6: alternating widths, plain interrupt
    cur_req = "R1 R3 R6 alternating";
    wr(3'd0, 16'd4);
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd3);
    wr(3'd4, 16'b001);
    en = 1'b1;
    run(40);

    // R4: alternation off
    cur_req = "R4 fixed width A";
    wr(3'd4, 16'b000);
    run(30);

    // R1: enable gaps freeze everything
    cur_req = "R1 enable gaps";
    wr(3'd4, 16'b001);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); en = (i % 3) != 1;
    end
    en = 1'b1;

    // R7: decimated, phase 1 only, every 2nd counted zero
    cur_req = "R7 decim pol1 n2";
    wr(3'd3, 16'd2);
    wr(3'd4, 16'b111);
    run(80);

    // R7: polarity 0, setting 0 acts as 1
    cur_req = "R7 decim pol0 n0";
    wr(3'd3, 16'd0);
    wr(3'd4, 16'b011);
    run(40);

    // R7: decimation with alternation off (phase always 0)
    cur_req = "R7 decim no-alt";
    wr(3'd3, 16'd3);
    wr(3'd4, 16'b010);
    run(40);

    // R5: width longer than period, and width 0
    cur_req = "R5 restart and zero width";
    wr(3'd4, 16'b001);
    wr(3'd1, 16'd9);
    wr(3'd2, 16'd0);
    wr(3'd0, 16'd3);
    run(40);
    wr(3'd1, 16'd4);   // expiry on the same clock as the next zero
    run(30);

    // R8: mid-period writes and spare addresses
    cur_req = "R8 deferred writes";
    wr(3'd0, 16'd12);
    run(5);
    wr(3'd0, 16'd2);
    wr(3'd5, 16'hFFFF);
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0005);
    run(40);

    // R1: zero-length period, zero every enabled clock
    cur_req = "R1 period zero";
    wr(3'd0, 16'd0);
    run(20);
    wr(3'd0, 16'd1);
    run(20);

    run(2);
    report();
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired (%s) actual=running expected=finished", cur_req);
    report();
  end

endmodule